// File: doc/BRIEF.md
# Image Checksum and Self-Verify Unit

This block supervises an in-field firmware update. Each data byte that the write engine commits to memory is added into a 16-bit running sum, and each byte that the memory returns on read-back is compared with the byte last written. Any difference raises a flag that stays set. Bytes that belong to control frames never reach the sum.

A one-byte command with a 16-bit argument, split into a low byte and a high byte, drives the unit. One code clears the sum and all status. One code asks for a device reset. One code runs the final check: the host supplies the two's complement of the total it sent, and the unit adds that value to its own sum. When the result is zero and no read-back mismatch was seen, the unit writes the normal-execution value into the non-volatile boot flag location, which commits the new image. When the check fails, the boot flag is left alone and a failure status is held. Every other command code does nothing.

Top module: `imgchk_top`

## Requirements
- R1: After reset, `verify_fail`, `sum_ok`, `run_fail`, `reset_req` and `flag_we` are all 0.
- R2: A byte on `wr_byte` enters the sum only when `wr_valid` and `wr_is_mem` are both 1. The byte is zero-extended and added modulo 2^16. A byte with `wr_is_mem`=0 is a control byte and leaves the sum unchanged.
- R3: Command code 03h is check-and-run. When the running sum plus {`cmd_arg_hi`,`cmd_arg_lo`} is 0 modulo 2^16 and `verify_fail` is 0, then on the cycle after the command `sum_ok` is 1 and `flag_we` is 1 for exactly that one cycle. Check-and-run does not change the sum.
- R4: A check-and-run that does not pass sets `run_fail`, clears `sum_ok` and writes no boot flag. `run_fail` stays at 1 until the next code 02h.
- R5: With self-verify enabled, a `rb_valid` byte that differs from the most recent memory byte written sets `verify_fail`. `verify_fail` stays set until code 02h, and while it is set no check-and-run can pass.
- R6: Command code 02h sets the sum to 0 and clears `verify_fail`, `sum_ok` and `run_fail` on the next cycle.
- R7: Command code 01h raises `reset_req` for exactly one cycle, on the cycle after the command.
- R8: Code 00h and codes 04h to FFh leave the sum and all outputs unchanged: they raise neither `reset_req` nor `flag_we`.
- R9: The boot flag value FFh means boot mode, and any other value means normal mode. `flag_wdata` carries the normal-mode value (00h by default) and is never FFh.
- R10: When code 02h arrives in the same cycle as a memory byte, the clear takes precedence and the byte is discarded. A check-and-run uses the sum as it stood before any byte that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | A byte is being written this cycle |
| wr_byte | input | 8 | Byte being written |
| wr_is_mem | input | 1 | 1 = memory data byte, 0 = control frame byte |
| rb_valid | input | 1 | A read-back byte is present this cycle |
| rb_byte | input | 8 | Byte read back from memory |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code: 00h no-op, 01h reset, 02h init, 03h check-and-run |
| cmd_arg_lo | input | 8 | Low byte of the check argument |
| cmd_arg_hi | input | 8 | High byte of the check argument |
| verify_fail | output | 1 | Sticky read-back mismatch flag |
| sum_ok | output | 1 | The last check-and-run passed |
| run_fail | output | 1 | Sticky failed-check status |
| reset_req | output | 1 | One-cycle software reset request |
| flag_we | output | 1 | Write strobe to the boot flag location |
| flag_wdata | output | 8 | Value written to the boot flag location |

## Verification
The bench sends enough 0xFF bytes that the sum wraps past 2^16. A design that saturated the sum, or that carried the overflow, would reject a correct complement. Control bytes are placed among the memory bytes, so any leak of a control byte into the sum turns a pass into a fail. The bench drives a clear and a memory byte in the same cycle, and a check-and-run and a byte in the same cycle. A unit with the wrong precedence would see a nonzero sum where zero is expected, or the reverse. The bench also sends a mismatched read-back before a check whose argument is otherwise correct, and it sends unused command codes after a pass. A unit that ignored the verify flag, or that decoded only the low bits of the code, would then commit the flag or raise a reset.

// File: rtl/imgchk_pkg.sv
package imgchk_pkg;

   typedef enum logic [7:0] {
      CK_NOP   = 8'h00,
      CK_RESET = 8'h01,
      CK_INIT  = 8'h02,
      CK_RUN   = 8'h03
   } ck_code_e;

   typedef struct packed {
      logic rst;
      logic init;
      logic run;
   } ck_dec_t;

endpackage

// File: rtl/imgchk_decode.sv
module imgchk_decode
   import imgchk_pkg::*;
(
   input  logic       cmd_valid,
   input  logic [7:0] cmd_code,
   output ck_dec_t    dec
);
   always_comb begin
      dec = '0;
      if (cmd_valid) begin
         unique case (cmd_code)
            CK_RESET: dec.rst  = 1'b1;
            CK_INIT:  dec.init = 1'b1;
            CK_RUN:   dec.run  = 1'b1;
            default:  dec      = '0;
         endcase
      end
   end
endmodule

// File: rtl/imgchk_accum.sv
module imgchk_accum #(
   parameter int BYTE_W = 8,
   parameter int SUM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add_en,
   input  logic [BYTE_W-1:0] add_byte,
   output logic [SUM_W-1:0]  sum_q
);
   localparam int PAD_W = SUM_W - BYTE_W;

   logic [SUM_W-1:0] ext;
   assign ext = {{PAD_W{1'b0}}, add_byte};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      sum_q <= '0;
      else if (clr)    sum_q <= '0;
      else if (add_en) sum_q <= sum_q + ext;
   end
endmodule

// File: rtl/imgchk_verify.sv
module imgchk_verify #(
   parameter int BYTE_W    = 8,
   parameter bit VERIFY_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              rb_valid,
   input  logic [BYTE_W-1:0] rb_byte,
   output logic              fail_q
);
   generate
      if (VERIFY_EN) begin : g_on
         logic [BYTE_W-1:0] ref_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     ref_q <= '0;
            else if (wr_en) ref_q <= wr_byte;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                           fail_q <= 1'b0;
            else if (clr)                         fail_q <= 1'b0;
            else if (rb_valid && rb_byte != ref_q) fail_q <= 1'b1;
         end
      end else begin : g_off
         logic unused;
         assign unused = clk ^ rst_n ^ clr ^ wr_en ^ (^wr_byte) ^ rb_valid ^ (^rb_byte);
         assign fail_q = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/imgchk_top.sv
module imgchk_top
   import imgchk_pkg::*;
#(
   parameter int              BYTE_W      = 8,
   parameter int              SUM_W       = 16,
   parameter bit              VERIFY_EN   = 1'b1,
   parameter logic [BYTE_W-1:0] FLAG_NORMAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic              wr_is_mem,
   input  logic              rb_valid,
   input  logic [BYTE_W-1:0] rb_byte,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_code,
   input  logic [BYTE_W-1:0] cmd_arg_lo,
   input  logic [BYTE_W-1:0] cmd_arg_hi,
   output logic              verify_fail,
   output logic              sum_ok,
   output logic              run_fail,
   output logic              reset_req,
   output logic              flag_we,
   output logic [BYTE_W-1:0] flag_wdata
);
   localparam logic [BYTE_W-1:0] FLAG_BOOT = '1;

   generate
      if (SUM_W != 2*BYTE_W) begin : g_bad_width
         $error("SUM_W must be twice BYTE_W");
      end
      if (FLAG_NORMAL == FLAG_BOOT) begin : g_bad_flag
         $error("FLAG_NORMAL must differ from the boot-mode value");
      end
   endgenerate

   ck_dec_t          dec;
   logic [SUM_W-1:0] sum_q;
   logic [SUM_W-1:0] total;
   logic             pass;
   logic             mem_wr;

   assign mem_wr = wr_valid && wr_is_mem;

   imgchk_decode u_dec (
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .dec       (dec)
   );

   imgchk_accum #(.BYTE_W(BYTE_W), .SUM_W(SUM_W)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (dec.init),
      .add_en   (mem_wr),
      .add_byte (wr_byte),
      .sum_q    (sum_q)
   );

   imgchk_verify #(.BYTE_W(BYTE_W), .VERIFY_EN(VERIFY_EN)) u_ver (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (dec.init),
      .wr_en    (mem_wr),
      .wr_byte  (wr_byte),
      .rb_valid (rb_valid),
      .rb_byte  (rb_byte),
      .fail_q   (verify_fail)
   );

   assign total = sum_q + {cmd_arg_hi, cmd_arg_lo};
   assign pass  = (total == '0) && !verify_fail;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reset_req <= 1'b0;
         flag_we   <= 1'b0;
         sum_ok    <= 1'b0;
         run_fail  <= 1'b0;
      end else begin
         reset_req <= dec.rst;
         flag_we   <= dec.run && pass;
         if (dec.init) begin
            sum_ok   <= 1'b0;
            run_fail <= 1'b0;
         end else if (dec.run) begin
            sum_ok <= pass;
            if (!pass) run_fail <= 1'b1;
         end
      end
   end

   assign flag_wdata = FLAG_NORMAL;
endmodule

// File: rtl/imgchk_chk.sv
module imgchk_chk #(
   parameter int BYTE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic [7:0]        cmd_code,
   input logic              verify_fail,
   input logic              sum_ok,
   input logic              run_fail,
   input logic              reset_req,
   input logic              flag_we,
   input logic [BYTE_W-1:0] flag_wdata
);
   p_rst_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> !reset_req);
   p_rst_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> $past(cmd_valid && cmd_code == 8'h01));
   p_flag_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> (flag_wdata != '1));
   p_flag_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> sum_ok);
   p_flag_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flag_we |-> $past(cmd_valid && cmd_code == 8'h03));
   p_vf_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (verify_fail && !(cmd_valid && cmd_code == 8'h02)) |=> verify_fail);
   p_fail_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_fail && !(cmd_valid && cmd_code == 8'h02)) |=> run_fail);
   p_init_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 8'h02) |=> (!verify_fail && !sum_ok && !run_fail));
   p_nop_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_code == 8'h00 || cmd_code >= 8'h04)) |=> (!reset_req && !flag_we));
endmodule

bind imgchk_top imgchk_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_valid   (cmd_valid),
   .cmd_code    (cmd_code),
   .verify_fail (verify_fail),
   .sum_ok      (sum_ok),
   .run_fail    (run_fail),
   .reset_req   (reset_req),
   .flag_we     (flag_we),
   .flag_wdata  (flag_wdata)
);

// File: tb/sim_imgchk_top.sv
`timescale 1ns/1ps
module sim_imgchk_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_valid = 1'b0, wr_is_mem = 1'b0, rb_valid = 1'b0, cmd_valid = 1'b0;
   logic [7:0] wr_byte = '0, rb_byte = '0, cmd_code = '0, cmd_arg_lo = '0, cmd_arg_hi = '0;
   logic       verify_fail, sum_ok, run_fail, reset_req, flag_we;
   logic [7:0] flag_wdata;

   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;
   logic [15:0] m_sum = '0;

   always #4 clk = ~clk;

   imgchk_top u0 (
      .clk(clk), .rst_n(rst_n),
      .wr_valid(wr_valid), .wr_byte(wr_byte), .wr_is_mem(wr_is_mem),
      .rb_valid(rb_valid), .rb_byte(rb_byte),
      .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_arg_lo(cmd_arg_lo), .cmd_arg_hi(cmd_arg_hi),
      .verify_fail(verify_fail), .sum_ok(sum_ok), .run_fail(run_fail),
      .reset_req(reset_req), .flag_we(flag_we), .flag_wdata(flag_wdata)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic put_byte(input logic [7:0] b, input logic mem);
      @(negedge clk);
      wr_valid = 1'b1; wr_byte = b; wr_is_mem = mem;
      @(negedge clk);
      wr_valid = 1'b0; wr_is_mem = 1'b0;
      if (mem) m_sum = m_sum + {8'h00, b};
   endtask

   task automatic read_back(input logic [7:0] b);
      @(negedge clk);
      rb_valid = 1'b1; rb_byte = b;
      @(negedge clk);
      rb_valid = 1'b0;
   endtask

   task automatic send_cmd(input logic [7:0] code, input logic [15:0] arg);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = code; cmd_arg_lo = arg[7:0]; cmd_arg_hi = arg[15:8];
      @(negedge clk);
      cmd_valid = 1'b0;
      if (code == 8'h02) m_sum = '0;
   endtask

   function automatic logic [15:0] neg_sum();
      return 16'h0000 - m_sum;
   endfunction

   task automatic t_reset_state();
      chk(!verify_fail && !sum_ok && !run_fail && !reset_req && !flag_we, "R1 reset state",
          {verify_fail, sum_ok, run_fail, reset_req, flag_we}, 0);
   endtask

   task automatic t_basic_pass();
      send_cmd(8'h02, 16'h0);
      put_byte(8'h12, 1'b1);
      put_byte(8'h77, 1'b0);
      put_byte(8'h34, 1'b1);
      put_byte(8'hFF, 1'b1);
      send_cmd(8'h03, neg_sum());
      chk(sum_ok, "R2 control byte excluded, sum passes", sum_ok, 1);
      chk(flag_we, "R3 flag write on pass", flag_we, 1);
      chk(flag_wdata == 8'h00 && flag_wdata != 8'hFF, "R9 normal flag value", flag_wdata, 0);
      @(negedge clk);
      chk(!flag_we, "R3 flag strobe lasts one cycle", flag_we, 0);
   endtask

   task automatic t_fail();
      send_cmd(8'h02, 16'h0);
      put_byte(8'hA5, 1'b1);
      send_cmd(8'h03, neg_sum() + 16'h1);
      chk(!sum_ok && run_fail && !flag_we, "R4 wrong complement fails",
          {sum_ok, run_fail, flag_we}, 3'b010);
      send_cmd(8'h00, 16'h0);
      chk(run_fail, "R4 fail status sticky", run_fail, 1);
      send_cmd(8'h03, neg_sum());
      chk(sum_ok && run_fail, "R4 fail status held after later pass", {sum_ok, run_fail}, 2'b11);
      send_cmd(8'h02, 16'h0);
      chk(!run_fail && !sum_ok, "R6 init clears status", {sum_ok, run_fail}, 0);
   endtask

   task automatic t_wrap();
      send_cmd(8'h02, 16'h0);
      for (int i = 0; i < 300; i++) put_byte(8'hFF, 1'b1);
      chk(m_sum == 16'd10964, "R2 bench model wrap", m_sum, 10964);
      send_cmd(8'h03, 16'hD52C);
      chk(sum_ok && flag_we, "R2 modulo 2^16 sum passes", {sum_ok, flag_we}, 2'b11);
   endtask

   task automatic t_verify();
      send_cmd(8'h02, 16'h0);
      put_byte(8'h5A, 1'b1);
      read_back(8'h5A);
      chk(!verify_fail, "R5 matching read-back", verify_fail, 0);
      read_back(8'h5B);
      chk(verify_fail, "R5 mismatch sets flag", verify_fail, 1);
      put_byte(8'h11, 1'b1);
      read_back(8'h11);
      chk(verify_fail, "R5 flag sticky", verify_fail, 1);
      send_cmd(8'h03, neg_sum());
      chk(!sum_ok && run_fail && !flag_we, "R5 verify fail blocks pass",
          {sum_ok, run_fail, flag_we}, 3'b010);
      send_cmd(8'h02, 16'h0);
      chk(!verify_fail, "R6 init clears verify flag", verify_fail, 0);
      send_cmd(8'h03, 16'h0);
      chk(sum_ok, "R6 init zeroes sum", sum_ok, 1);
   endtask

   task automatic t_reset_cmd();
      send_cmd(8'h01, 16'h0);
      chk(reset_req, "R7 reset request raised", reset_req, 1);
      @(negedge clk);
      chk(!reset_req, "R7 reset request one cycle", reset_req, 0);
   endtask

   task automatic t_unused_codes();
      send_cmd(8'h02, 16'h0);
      put_byte(8'h3C, 1'b1);
      send_cmd(8'h03, neg_sum());
      chk(sum_ok, "R8 setup pass", sum_ok, 1);
      send_cmd(8'h04, 16'h0);
      chk(!reset_req && !flag_we && sum_ok, "R8 code 04h no effect", {reset_req, flag_we, sum_ok}, 1);
      send_cmd(8'h83, 16'h0);
      chk(!reset_req && !flag_we && sum_ok && !run_fail, "R8 code 83h no effect",
          {reset_req, flag_we, sum_ok, run_fail}, 2);
      send_cmd(8'hFF, 16'h0);
      chk(!reset_req && !flag_we, "R8 code FFh no effect", {reset_req, flag_we}, 0);
      send_cmd(8'h00, 16'h0);
      chk(!reset_req && !flag_we && sum_ok, "R8 code 00h no effect", {reset_req, flag_we, sum_ok}, 1);
      send_cmd(8'h03, neg_sum());
      chk(sum_ok && flag_we, "R8 sum unchanged by unused codes", {sum_ok, flag_we}, 2'b11);
   endtask

   task automatic t_same_cycle();
      send_cmd(8'h02, 16'h0);
      put_byte(8'h20, 1'b1);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'h02; cmd_arg_lo = 8'h00; cmd_arg_hi = 8'h00;
      wr_valid = 1'b1; wr_is_mem = 1'b1; wr_byte = 8'h40;
      @(negedge clk);
      cmd_valid = 1'b0; wr_valid = 1'b0; wr_is_mem = 1'b0;
      m_sum = '0;
      send_cmd(8'h03, 16'h0);
      chk(sum_ok, "R10 init wins over same-cycle byte", sum_ok, 1);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_code = 8'h03; cmd_arg_lo = 8'h00; cmd_arg_hi = 8'h00;
      wr_valid = 1'b1; wr_is_mem = 1'b1; wr_byte = 8'h10;
      @(negedge clk);
      cmd_valid = 1'b0; wr_valid = 1'b0; wr_is_mem = 1'b0;
      m_sum = 16'h0010;
      chk(sum_ok && flag_we, "R10 check uses sum before same-cycle byte", {sum_ok, flag_we}, 2'b11);
      send_cmd(8'h03, 16'h0);
      chk(!sum_ok && run_fail, "R10 same-cycle byte added afterwards", {sum_ok, run_fail}, 2'b01);
      send_cmd(8'h03, neg_sum());
      chk(sum_ok, "R2 sum holds 10h", sum_ok, 1);
   endtask

   task automatic report();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_basic_pass();
      t_fail();
      t_wrap();
      t_verify();
      t_reset_cmd();
      t_unused_codes();
      t_same_cycle();
      done = 1'b1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0h expected=%0h", 0, 1);
         report();
         $finish;
      end
   end
endmodule